// File: doc/BRIEF.md
# Partially unrolled PAM4 decision feedback equalizer

The block cancels trailing intersymbol interference from a stream of PAM4 samples using decision feedback over a parameterised number of past symbols (five by default). The multiply-and-subtract is taken out of the feedback loop. For every sample, a sign test on the incoming value narrows that symbol slot to three adjacent levels. A precompute stage then forms the equalized value, and its sliced decision, for every combination of candidates across the past slots. This gives 3^N entries (243 by default) rather than 4^N. These results are registered. One cycle later, the true past decisions steer a single three-way-per-tap selection tree, so the loop holds only that tree and a small code conversion.

A true past decision is not always inside its slot's three-level set. In that case the nearest member of the set is fed back instead. Tap coefficients come in on a configuration input and are expected to be held steady while samples stream. One sample is accepted on every clock edge. Each result leaves two edges later as a 2-bit decision code and a full-width equalized value.

Top module: `pam4_pu_dfe`

## Requirements
- R1: The equalized output equals the sample minus the sum over taps k = 1..N of coefficient k times the fed-back level of the symbol k places earlier, computed exactly on EW = W+3+clog2(N) signed bits.
- R2: The decision code is derived from the equalized value y with U = 256 by default: code 0 (level -3) when y < -2U; code 1 (level -1) when -2U <= y < 0; code 2 (level +1) when 0 <= y < 2U; code 3 (level +3) when y >= 2U.
- R3: Each symbol slot has a candidate set chosen from its own sample's sign bit. A negative sample gives {-3, -1, +1}. A zero or positive sample gives {-1, +1, +3}. Only members of that set are ever fed back for the slot.
- R4: When a slot's decision lies outside its candidate set, the nearest member is fed back. A +3 decision on a negative sample feeds back +1, and a -3 decision on a non-negative sample feeds back -1.
- R5: Coefficient k (1-based) is the signed W-bit field coef_i[(k-1)*W +: W] and acts on the decision k symbols before the current one.
- R6: A sample captured on clock edge n appears on dec_o and eq_o after edge n+2, with one new result per cycle.
- R7: During reset and for the first two edges after it, eq_o reads 0 and dec_o reads code 2. The first sample after reset sees a history of N decisions of +1, all on non-negative slots.
- R8: With all coefficients zero, eq_o equals the sample sign-extended to EW bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| coef_i | input | N*W | Packed signed tap coefficients, tap 1 in the low field |
| x_i | input | W | Signed feed-forward sample, one per cycle |
| dec_o | output | 2 | Decision code, 0..3 for levels -3, -1, +1, +3 |
| eq_o | output | EW | Signed equalized value of the decided sample |

## Verification
The hardest case to reach from the ports is a decision that falls outside its own slot's candidate set. It occurs only when the feedback term outweighs a small sample of the opposite sign, and it changes nothing until a later symbol reads the substituted level back through a tap. Directed runs create it on purpose. They use one strong tap against small samples of opposite sign, first with a negative tap and then with a positive one, so that both the +3-to-+1 and the -3-to--1 substitutions occur. Random runs with full-scale coefficients then hit it many times over, and a reference model that applies the nearest-candidate rule checks every following output.

// File: rtl/pam4_dfe_pkg.sv
`timescale 1ns/1ps
package pam4_dfe_pkg;
  // decision code: 0:-3 1:-1 2:+1 3:+3
  typedef logic [1:0] code_t;

  function automatic code_t slice_code(input int y, input int thr);
    if (y < -thr) return 2'd0;
    if (y < 0)    return 2'd1;
    if (y < thr)  return 2'd2;
    return 2'd3;
  endfunction

  // index into a slot's three-level set, nearest member when outside
  function automatic logic [1:0] code_to_idx(input code_t c, input logic neg);
    if (neg) return (c == 2'd3) ? 2'd2 : c;
    return (c == 2'd0) ? 2'd0 : c - 2'd1;
  endfunction

  function automatic code_t idx_to_code(input logic [1:0] idx, input logic neg);
    return neg ? idx : idx + 2'd1;
  endfunction
endpackage

// File: rtl/pam4_tap_terms.sv
`timescale 1ns/1ps
module pam4_tap_terms #(
  parameter int W = 12,
  parameter int N = 5,
  localparam int TW = W + 2
) (
  input  logic [N*W-1:0]    coef_i,
  input  logic [N-1:0]      neg_i,
  output logic [N*3*TW-1:0] terms_o
);
  for (genvar k = 0; k < N; k++) begin : g_tap
    logic signed [TW-1:0] b1, b3;
    assign b1 = TW'($signed(coef_i[k*W +: W]));
    assign b3 = (b1 <<< 1) + b1;
    // entries 0..2 are the lowest..highest level of this slot's set
    assign terms_o[(3*k+0)*TW +: TW] = neg_i[k] ? -b3 : -b1;
    assign terms_o[(3*k+1)*TW +: TW] = neg_i[k] ? -b1 :  b1;
    assign terms_o[(3*k+2)*TW +: TW] = neg_i[k] ?  b1 :  b3;
  end
endmodule

// File: rtl/pam4_cand_sums.sv
`timescale 1ns/1ps
module pam4_cand_sums
  import pam4_dfe_pkg::*;
#(
  parameter int W  = 12,
  parameter int N  = 5,
  parameter int U  = 256,
  parameter int EW = 18,
  localparam int TW = W + 2,
  localparam int NC = 3 ** N
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic signed [W-1:0]  x_i,
  input  logic [N*3*TW-1:0]    terms_i,
  output logic [NC*EW-1:0]     pre_y_o,
  output logic [NC*2-1:0]      pre_d_o
);
  for (genvar c = 0; c < NC; c++) begin : g_cmb
    logic signed [EW-1:0] acc [N+1];
    logic signed [EW-1:0] y_q;
    code_t                d_q;

    assign acc[0] = EW'(x_i);
    for (genvar k = 0; k < N; k++) begin : g_k
      localparam int DIG = (c / (3 ** k)) % 3;
      assign acc[k+1] = acc[k] - EW'($signed(terms_i[(3*k+DIG)*TW +: TW]));
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        y_q <= '0;
        d_q <= 2'd2;
      end else begin
        y_q <= acc[N];
        d_q <= slice_code(int'(acc[N]), 2 * U);
      end
    end

    assign pre_y_o[c*EW +: EW] = y_q;
    assign pre_d_o[c*2 +: 2]   = d_q;
  end
endmodule

// File: rtl/pam4_mux3_tree.sv
`timescale 1ns/1ps
module pam4_mux3_tree #(
  parameter int N  = 5,
  parameter int DW = 20,
  localparam int NC = 3 ** N
) (
  input  logic [NC*DW-1:0] in_i,
  input  logic [2*N-1:0]   sel_i,
  output logic [DW-1:0]    out_o
);
  function automatic int lvl_off(input int j);
    int o = 0;
    for (int t = 0; t < j; t++) o += 3 ** (N - t);
    return o;
  endfunction

  localparam int TOT = lvl_off(N) + 1;

  logic [DW-1:0] node [TOT];

  for (genvar m = 0; m < NC; m++) begin : g_leaf
    assign node[m] = in_i[m*DW +: DW];
  end

  // level j resolves the digit of tap j+1
  for (genvar j = 0; j < N; j++) begin : g_lvl
    localparam int SRC = lvl_off(j);
    localparam int DST = lvl_off(j + 1);
    localparam int CNT = 3 ** (N - j - 1);
    logic [1:0] s;
    assign s = sel_i[2*j +: 2];
    for (genvar m = 0; m < CNT; m++) begin : g_node
      assign node[DST+m] = (s == 2'd0) ? node[SRC+3*m]   :
                           (s == 2'd1) ? node[SRC+3*m+1] : node[SRC+3*m+2];
    end
  end

  assign out_o = node[lvl_off(N)];
endmodule

// File: rtl/pam4_pu_dfe.sv
`timescale 1ns/1ps
module pam4_pu_dfe
  import pam4_dfe_pkg::*;
#(
  parameter int W = 12,
  parameter int N = 5,
  parameter int U = 256,
  localparam int EW = W + 3 + $clog2(N),
  localparam int TW = W + 2,
  localparam int NC = 3 ** N,
  localparam int DW = EW + 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [N*W-1:0]       coef_i,
  input  logic signed [W-1:0]  x_i,
  output logic [1:0]           dec_o,
  output logic signed [EW-1:0] eq_o
);
  logic signed [W-1:0]   x_a_q;
  logic                  a_vld_q, b_vld_q, o_vld_q;
  logic [N-1:0]          neg_hist_q;   // bit k: sign of sample k+1 before stage A
  logic                  neg_b_q, neg_o_q;
  logic [2*N-1:0]        idx_hist_q;   // field k: index of decision k+1 back
  logic [N*3*TW-1:0]     terms;
  logic [NC*EW-1:0]      pre_y;
  logic [NC*2-1:0]       pre_d;
  logic [NC*DW-1:0]      pre_pk;
  logic [DW-1:0]         pick;
  logic signed [EW-1:0]  y_sel;
  code_t                 d_sel;

  // stage A: capture sample, keep sign history for candidate sets
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_a_q      <= '0;
      a_vld_q    <= 1'b0;
      b_vld_q    <= 1'b0;
      neg_b_q    <= 1'b0;
      neg_hist_q <= '0;
    end else begin
      x_a_q   <= x_i;
      a_vld_q <= 1'b1;
      b_vld_q <= a_vld_q;
      neg_b_q <= x_a_q[W-1];
      if (a_vld_q) neg_hist_q <= {neg_hist_q[N-2:0], x_a_q[W-1]};
    end
  end

  pam4_tap_terms #(.W(W), .N(N)) u_terms (
    .coef_i  (coef_i),
    .neg_i   (neg_hist_q),
    .terms_o (terms)
  );

  pam4_cand_sums #(.W(W), .N(N), .U(U), .EW(EW)) u_sums (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .x_i     (x_a_q),
    .terms_i (terms),
    .pre_y_o (pre_y),
    .pre_d_o (pre_d)
  );

  for (genvar c = 0; c < NC; c++) begin : g_pack
    assign pre_pk[c*DW +: DW] = {pre_y[c*EW +: EW], pre_d[c*2 +: 2]};
  end

  pam4_mux3_tree #(.N(N), .DW(DW)) u_sel (
    .in_i  (pre_pk),
    .sel_i (idx_hist_q),
    .out_o (pick)
  );

  assign y_sel = pick[DW-1:2];
  assign d_sel = pick[1:0];

  // stage B: feedback loop is mux tree plus code-to-index
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_hist_q <= {N{2'd1}};
      dec_o      <= 2'd2;
      eq_o       <= '0;
      o_vld_q    <= 1'b0;
      neg_o_q    <= 1'b0;
    end else if (b_vld_q) begin
      idx_hist_q <= {idx_hist_q[2*N-3:0], code_to_idx(d_sel, neg_b_q)};
      dec_o      <= d_sel;
      eq_o       <= y_sel;
      o_vld_q    <= 1'b1;
      neg_o_q    <= neg_b_q;
    end
  end

  logic [1:0] newest_code;
  assign newest_code = idx_to_code(idx_hist_q[1:0], neg_o_q);

  assert_dec_slice_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_o == slice_code(int'(eq_o), 2 * U));

  for (genvar k = 0; k < N; k++) begin : g_chk
    assert_sel_legal_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      idx_hist_q[2*k +: 2] != 2'd3);
  end

  assert_fb_nearest_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    o_vld_q |-> (newest_code == dec_o) ||
                (neg_o_q && dec_o == 2'd3 && newest_code == 2'd2) ||
                (!neg_o_q && dec_o == 2'd0 && newest_code == 2'd1));

  assert_reset_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !o_vld_q |-> (dec_o == 2'd2 && eq_o == '0));

  assert_zero_taps_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (o_vld_q && $past(coef_i, 2) == '0) |-> eq_o == EW'($past(x_i, 3)));
endmodule

// File: tb/pam4_pu_dfe_bench.sv
`timescale 1ns/1ps
module pam4_pu_dfe_bench;
  localparam int W = 12;
  localparam int N = 5;
  localparam int U = 256;
  localparam int EW = W + 3 + $clog2(N);
  localparam int MAXS = 512;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic [N*W-1:0]       coef = '0;
  logic signed [W-1:0]  x = '0;
  logic [1:0]           dec;
  logic signed [EW-1:0] eq;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;
  int b [N];
  int xs [MAXS];
  int e_eq [MAXS];
  int e_dec [MAXS];

  always #5 clk = ~clk;

  pam4_pu_dfe #(.W(W), .N(N), .U(U)) u_pam4_pu_dfe (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .coef_i (coef),
    .x_i    (x),
    .dec_o  (dec),
    .eq_o   (eq)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int slice_ref(input int y);
    if (y < -2 * U) return 0;
    if (y < 0) return 1;
    if (y < 2 * U) return 2;
    return 3;
  endfunction

  function automatic int rnd(input int a);
    return int'($urandom_range(2 * a)) - a;
  endfunction

  // reference: R1 sum, R2 slicer, R3/R4 nearest-candidate feedback, R7 initial history
  task automatic build_exp(input int len);
    int hl [N];
    for (int k = 0; k < N; k++) hl[k] = 1;
    for (int i = 0; i < len; i++) begin
      int y;
      int lvl;
      y = xs[i];
      for (int k = 0; k < N; k++) y -= b[k] * hl[k];
      e_eq[i]  = y;
      e_dec[i] = slice_ref(y);
      lvl = 2 * e_dec[i] - 3;
      if (xs[i] < 0 && lvl == 3) lvl = 1;
      if (xs[i] >= 0 && lvl == -3) lvl = -1;
      for (int k = N - 1; k > 0; k--) hl[k] = hl[k-1];
      hl[0] = lvl;
    end
  endtask

  task automatic run(input int len, input string req_eq, input string req_dec);
    build_exp(len);
    @(negedge clk);
    rst_n = 1'b0;
    x = '0;
    for (int k = 0; k < N; k++) coef[k*W +: W] = W'(b[k]);
    repeat (2) @(negedge clk);
    chk("R7", "eq in reset", int'(eq), 0);
    chk("R7", "dec in reset", int'(dec), 2);
    rst_n = 1'b1;
    for (int k = 0; k < len + 2; k++) begin
      int j;
      x = (k < len) ? W'(xs[k]) : '0;
      @(negedge clk);
      j = k - 2;
      if (j < 0) begin
        chk("R7", "eq after reset", int'(eq), 0);
        chk("R7", "dec after reset", int'(dec), 2);
      end else begin
        chk((j == 0) ? "R6" : req_eq, "eq", int'(eq), e_eq[j]);
        chk(req_dec, "dec", int'(dec), e_dec[j]);
      end
    end
  endtask

  initial begin
    void'($urandom(32'd20251));

    // R8: zero taps, full-range random samples
    for (int k = 0; k < N; k++) b[k] = 0;
    for (int i = 0; i < 200; i++) xs[i] = rnd(2047);
    run(200, "R8", "R2");

    // R2: slicer boundaries with zero taps
    xs[0] = 512;  xs[1] = 511;  xs[2] = 0;     xs[3] = -1;
    xs[4] = -512; xs[5] = -513; xs[6] = 2047;  xs[7] = -2048;
    xs[8] = 1023; xs[9] = -1024;
    run(10, "R8", "R2");

    // R4: +3 decisions on negative slots fed back as +1
    b[0] = -1000;
    xs[0] = -10; xs[1] = 0;  xs[2] = -5; xs[3] = -20;
    xs[4] = 100; xs[5] = -3; xs[6] = -1; xs[7] = 40;
    run(8, "R4", "R2");

    // R4: -3 decisions on non-negative slots fed back as -1
    b[0] = 1000;
    xs[0] = 5;  xs[1] = 5;  xs[2] = 0;  xs[3] = -5;
    xs[4] = 7;  xs[5] = 30; xs[6] = 0;  xs[7] = 2;
    run(8, "R4", "R2");

    // R5: single tap at distance 3
    for (int k = 0; k < N; k++) b[k] = 0;
    b[2] = 300;
    for (int i = 0; i < 300; i++) xs[i] = rnd(1500);
    run(300, "R5", "R2");

    // R1: moderate random taps
    for (int k = 0; k < N; k++) b[k] = rnd(400);
    for (int i = 0; i < 500; i++) xs[i] = rnd(2047);
    run(500, "R1", "R2");

    // R3: samples near zero so candidate sets flip often
    for (int k = 0; k < N; k++) b[k] = rnd(150);
    b[0] = 600;
    for (int i = 0; i < 300; i++) xs[i] = rnd(300);
    run(300, "R3", "R2");

    // R4: full-scale random taps
    for (int k = 0; k < N; k++) b[k] = rnd(2047);
    for (int i = 0; i < 500; i++) xs[i] = rnd(2047);
    run(500, "R4", "R2");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule